// File: doc/BRIEF.md
# Guarded Nonvolatile Byte-Store Write Controller

This block sits between a small CPU register interface and a 128-byte nonvolatile data store, modelled here as on-chip registers. Software sees three registers: an address register, a data register and a control register. Reads go through the data register. A read strobe copies the addressed byte into the data register on the next clock edge.

A write is guarded against stray stores. Software must first set an arming bit. The arming bit clears itself in hardware after a short window. The write strobe counts only if it lands while the arming bit is still set, and it must come in a later register write than the one that armed. An accepted write then starts a self-timed programming interval of `WRITE_CYCLES` clocks. During that interval the write strobe reads as one, and software polls it. At the end of the interval the data register value is stored at the addressed location and the strobe reads zero again. While the interval runs, the address and data registers are frozen and read strobes have no effect.

Top module: `nvm_write_ctrl`

## Requirements
- R1: Reset clears the arming bit and the busy flag, sets `addr_o` and `data_o` to zero, and leaves the contents of the store unchanged.
- R2: A register write selects its target with `bus_sel`: 0 is the address register, 1 is the data register, 2 is the control register and 3 has no target. The address register takes `bus_wdata[6:0]`, so it holds 7 bits and covers 128 locations.
- R3: In a control register write, bit 2 requests arming, bit 1 is the write strobe and bit 0 is the read strobe. The bits can be combined in one write.
- R4: After the edge that sets the arming bit, `arm_o` reads one for exactly `ARM_WINDOW` (4) cycles and then clears itself. A further arming request restarts the window.
- R5: A write strobe is accepted only if `arm_o` is already one at the edge that samples it and no write is busy. Acceptance clears the arming bit and raises `busy_o`.
- R6: A write strobe that arrives after the arming window has closed is ignored: `busy_o` stays zero and the store is unchanged.
- R7: A write strobe in the same control write that requests arming is ignored, because the arming bit is not yet set.
- R8: After acceptance, `busy_o` reads one for exactly `WRITE_CYCLES` cycles. In the cycle it falls, the data register value is stored at the addressed location.
- R9: A read strobe while no write is busy loads the addressed byte into `data_o` at the next edge.
- R10: A read strobe while a write is busy has no effect on `data_o`.
- R11: Writes to the address or data register while a write is busy are ignored, and the write in progress stores its original address and value.
- R12: A write stores the most recent address and data register values. Loading them before arming is optional, and the registers can be loaded in either order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write request for this cycle |
| bus_sel | input | 2 | Register select (0 address, 1 data, 2 control) |
| bus_wdata | input | 8 | Register write data |
| addr_o | output | 7 | Current address register |
| data_o | output | 8 | Current data register |
| arm_o | output | 1 | Arming bit readback |
| busy_o | output | 1 | Write strobe readback, high while programming |

## Verification
If the arming counter is off by one, a strobe at the edge of the window is taken or refused wrongly. This shows in `busy_o` one cycle after the strobe. A programming counter of the wrong length shows as a busy interval that differs from `WRITE_CYCLES` when it is counted at the ports. A wrong commit address or value, or a register that is not frozen, stays hidden until a later read strobe returns the wrong byte. The bench therefore writes every location and then reads every location back, so an error in the store path appears at the latest in the full read sweep.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_RD_BIT  = 0;
  localparam int unsigned CTRL_WR_BIT  = 1;
  localparam int unsigned CTRL_ARM_BIT = 2;

  // A down-counter that reaches zero ends its interval at the next edge.
  function automatic logic last_tick(input int unsigned remaining);
    return remaining == 0;
  endfunction

  // A write is granted when it is armed from an earlier cycle and the store is idle.
  function automatic logic grant_write(input logic strobe, input logic armed,
                                       input logic busy);
    return strobe && armed && !busy;
  endfunction

endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int unsigned WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic consume,
  output logic armed
);
  import nvm_pkg::*;

  localparam int unsigned CW = $clog2(WINDOW + 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      remain_q <= '0;
    end else if (consume) begin
      armed    <= 1'b0;
      remain_q <= '0;
    end else if (arm_req) begin
      armed    <= 1'b1;
      remain_q <= CW'(WINDOW - 1);
    end else if (armed) begin
      if (last_tick(int'(remain_q))) armed <= 1'b0;
      else remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int unsigned CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  import nvm_pkg::*;

  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain_q;

  assign done = busy && last_tick(int'(remain_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      remain_q <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      remain_q <= CW'(CYCLES - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  // No reset: the contents survive a reset of the controller.
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl #(
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ARM_WINDOW   = 4,
  parameter int unsigned WRITE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              arm_o,
  output logic              busy_o
);
  import nvm_pkg::*;

  // Named internal events, observed by the bound checker
  logic ctrl_wr, arm_set, wr_req, wr_accept, wr_commit, rd_take;
  logic addr_we, data_we, strobe_rejected;
  logic [DATA_W-1:0] rd_byte;

  assign ctrl_wr         = bus_wr && (reg_sel_e'(bus_sel) == SEL_CTRL);
  assign arm_set         = ctrl_wr && bus_wdata[CTRL_ARM_BIT];
  assign wr_req          = ctrl_wr && bus_wdata[CTRL_WR_BIT];
  assign wr_accept       = grant_write(wr_req, arm_o, busy_o);
  assign strobe_rejected = wr_req && !wr_accept;
  assign rd_take         = ctrl_wr && bus_wdata[CTRL_RD_BIT] && !busy_o;
  assign addr_we = bus_wr && (reg_sel_e'(bus_sel) == SEL_ADDR) && !busy_o;
  assign data_we = bus_wr && (reg_sel_e'(bus_sel) == SEL_DATA) && !busy_o;

  nvm_arm_window #(.WINDOW(ARM_WINDOW)) u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_req (arm_set),
    .consume (wr_accept),
    .armed   (arm_o)
  );

  nvm_prog_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_accept),
    .busy  (busy_o),
    .done  (wr_commit)
  );

  nvm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_commit),
    .addr  (addr_o),
    .wdata (data_o),
    .rdata (rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o <= '0;
      data_o <= '0;
    end else begin
      if (addr_we) addr_o <= bus_wdata[ADDR_W-1:0];
      if (rd_take) data_o <= rd_byte;
      else if (data_we) data_o <= bus_wdata;
    end
  end

endmodule

// File: rtl/nvm_write_ctrl_chk.sv
module nvm_write_ctrl_chk #(
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ARM_WINDOW   = 4,
  parameter int unsigned WRITE_CYCLES = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_set,
  input logic              wr_req,
  input logic              wr_accept,
  input logic              wr_commit,
  input logic              rd_take,
  input logic              arm_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] data_o
);
  localparam int unsigned AW = $clog2(ARM_WINDOW + 2) + 1;
  localparam int unsigned BW = $clog2(WRITE_CYCLES + 2) + 1;

  logic [AW-1:0] arm_age;
  logic [BW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n) arm_age <= '0;
    else if (arm_set && !wr_accept) arm_age <= AW'(1);
    else if (arm_o) arm_age <= arm_age + 1'b1;
    else arm_age <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_len <= '0;
    else if (wr_accept) busy_len <= BW'(1);
    else if (busy_o) busy_len <= busy_len + 1'b1;
    else busy_len <= '0;
  end

  AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |-> (arm_age <= AW'(ARM_WINDOW))); // R4

  AST_ACCEPT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> (arm_o && !busy_o)); // R5

  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (busy_o && !arm_o)); // R5

  AST_UNARMED_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !arm_o && !busy_o) |=> !busy_o); // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_len <= BW'(WRITE_CYCLES))); // R8

  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !busy_o); // R8

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !rd_take); // R10

  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !wr_commit) |=> ($stable(addr_o) && $stable(data_o))); // R11

endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .ARM_WINDOW(ARM_WINDOW), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm_set   (arm_set),
  .wr_req    (wr_req),
  .wr_accept (wr_accept),
  .wr_commit (wr_commit),
  .rd_take   (rd_take),
  .arm_o     (arm_o),
  .busy_o    (busy_o),
  .addr_o    (addr_o),
  .data_o    (data_o)
);

// File: tb/nvm_write_ctrl_bench.sv
module nvm_write_ctrl_bench;
  localparam int WC  = 20;
  localparam int WIN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_sel = 2'd3;
  logic [7:0] bus_wdata = 8'h00;
  logic [6:0] addr_o;
  logic [7:0] data_o;
  logic       arm_o, busy_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  nvm_write_ctrl #(.ARM_WINDOW(WIN), .WRITE_CYCLES(WC)) u_nvm_write_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .addr_o(addr_o), .data_o(data_o),
    .arm_o(arm_o), .busy_o(busy_o)
  );

  function automatic logic [7:0] pattern(input int a, input int pass);
    return 8'((a * 37 + pass * 91 + 11) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Drive one register write; returns at the negedge after the capturing edge.
  task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = val;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 2'd3; bus_wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count the samples for which busy_o stays high.
  task automatic busy_span(output int n);
    n = 0;
    while (busy_o && n < WC + 10) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_at(input int a, output logic [7:0] v);
    reg_write(2'd0, 8'(a));
    reg_write(2'd2, 8'h01);
    v = data_o;
  endtask

  // Arm, wait so that the strobe lands gap cycles after arming, then strobe.
  task automatic guarded_write(input int a, input logic [7:0] v, input int gap,
                               output int span);
    reg_write(2'd0, 8'(a));
    reg_write(2'd1, v);
    reg_write(2'd2, 8'h04);
    idle(gap - 1);
    reg_write(2'd2, 8'h02);
    busy_span(span);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    logic [7:0] rv;
    int span, n;

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(arm_o == 0 && busy_o == 0, "R1 ctrl", {arm_o, busy_o}, 0);
    chk(addr_o == 0 && data_o == 0, "R1 regs", {addr_o, data_o}, 0);

    // R2 address width and select decoding
    reg_write(2'd0, 8'hFF);
    chk(addr_o == 7'h7F, "R2 addr bit7 dropped", addr_o, 8'h7F);
    reg_write(2'd3, 8'h55);
    chk(addr_o == 7'h7F && data_o == 8'h00, "R2 select 3 no target", data_o, 0);

    // R4 arming window length
    reg_write(2'd2, 8'h04);
    n = 0;
    while (arm_o && n < 10) begin n++; @(negedge clk); end
    chk(n == WIN, "R4 arm length", n, WIN);
    // R4 restart of the window
    reg_write(2'd2, 8'h04);
    idle(2);
    reg_write(2'd2, 8'h04);
    n = 0;
    while (arm_o && n < 10) begin n++; @(negedge clk); end
    chk(n == WIN, "R4 rearm length", n, WIN);

    // R5 R8 R12 sweep: every location, every legal gap
    for (int a = 0; a < 128; a++) begin
      guarded_write(a, pattern(a, 0), (a % WIN) + 1, span);
      chk(span == WC, "R8 busy length", span, WC);
    end
    for (int a = 0; a < 128; a++) begin
      read_at(a, rv);
      chk(rv == pattern(a, 0), "R9 R5 readback", rv, pattern(a, 0));
    end

    // R3 R5 acceptance clears arming
    reg_write(2'd0, 8'd10);
    reg_write(2'd1, 8'h3C);
    reg_write(2'd2, 8'h04);
    reg_write(2'd2, 8'h02);
    chk(busy_o == 1 && arm_o == 0, "R5 accept", {arm_o, busy_o}, 1);
    busy_span(span);
    read_at(10, rv);
    chk(rv == 8'h3C, "R3 write strobe bit", rv, 8'h3C);

    // R6 strobe after window closed
    reg_write(2'd0, 8'd3);
    reg_write(2'd1, 8'hE7);
    reg_write(2'd2, 8'h04);
    idle(WIN);
    reg_write(2'd2, 8'h02);
    chk(busy_o == 0, "R6 late strobe busy", busy_o, 0);
    read_at(3, rv);
    chk(rv == pattern(3, 0), "R6 store unchanged", rv, pattern(3, 0));

    // R7 arm and strobe in one control write
    reg_write(2'd0, 8'd4);
    reg_write(2'd1, 8'h99);
    reg_write(2'd2, 8'h06);
    chk(busy_o == 0 && arm_o == 1, "R7 same-write strobe", {arm_o, busy_o}, 2);
    idle(WIN + 1);
    read_at(4, rv);
    chk(rv == pattern(4, 0), "R7 store unchanged", rv, pattern(4, 0));

    // R10 R11 frozen registers during programming
    reg_write(2'd0, 8'd5);
    reg_write(2'd1, 8'hA5);
    reg_write(2'd2, 8'h04);
    reg_write(2'd2, 8'h02);
    reg_write(2'd0, 8'd9);
    reg_write(2'd1, 8'h11);
    chk(addr_o == 7'd5 && data_o == 8'hA5, "R11 regs frozen", {addr_o, data_o}, 16'h05A5);
    reg_write(2'd2, 8'h01);
    chk(data_o == 8'hA5, "R10 read ignored", data_o, 8'hA5);
    busy_span(span);
    read_at(5, rv);
    chk(rv == 8'hA5, "R11 committed original", rv, 8'hA5);
    read_at(9, rv);
    chk(rv == pattern(9, 0), "R11 other location untouched", rv, pattern(9, 0));

    // R12 last values win, data loaded before address
    reg_write(2'd1, 8'h12);
    reg_write(2'd0, 8'd20);
    reg_write(2'd1, 8'h34);
    reg_write(2'd0, 8'd21);
    reg_write(2'd2, 8'h04);
    reg_write(2'd2, 8'h02);
    busy_span(span);
    read_at(21, rv);
    chk(rv == 8'h34, "R12 last values", rv, 8'h34);
    read_at(20, rv);
    chk(rv == pattern(20, 0), "R12 earlier address untouched", rv, pattern(20, 0));

    // R1 reset keeps store contents
    reg_write(2'd1, 8'h77);
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_o == 0 && data_o == 0 && !arm_o && !busy_o, "R1 reset regs", {addr_o, data_o}, 0);
    read_at(21, rv);
    chk(rv == 8'h34, "R1 store kept", rv, 8'h34);

    finish_run();
  end

endmodule